// File: doc/BRIEF.md
# Hotplug Slot Event Register Bank

This block is a small register bank that tells system firmware which PCI slots have just gained or lost a device. A platform-side request port supplies a slot number together with an insert or remove flag. Each request wipes the previous event picture, marks the single affected slot in either the arrival map or the departure map, raises a general-purpose event flag, enables that flag, and emits a one-cycle interrupt pulse toward the system controller.

Firmware reaches the bank over a plain 32-bit register bus with a byte address. Reads return data combinationally for the offset on the bus. Writes take effect at the clock edge on which the write strobe is sampled. Firmware acknowledges a device removal by writing a one-hot (or any nonzero) pattern to the eject register. The bank turns the lowest set bit of that pattern into a slot index, which it presents for one cycle with a valid strobe.

Register map (byte offsets, word aligned): 0x0 arrival map, 0x4 departure map, 0x8 eject, 0xC event register. In the event register, bits [15:0] hold the event status flags and bits [31:16] hold the event enable flags.

Top module: `hpe_regbank`

## Requirements
- R1: A bus write to offset 0x0 sets the full 32-bit arrival map and a write to 0x4 sets the departure map. A read of either offset returns the value last written there.
- R2: Any offset that is not word aligned (address bits [1:0] nonzero), and any offset at or above 0x10, reads as zero. A write to such an offset leaves every register unchanged.
- R3: A read of the eject register at offset 0x8 always returns zero.
- R4: A nonzero write to offset 0x8 raises `ej_valid` for exactly the one cycle after the write edge. In that cycle `ej_slot` equals the bit position of the lowest set bit of the written value.
- R5: A write of zero to offset 0x8 leaves `ej_valid` low.
- R6: Every hotplug request clears both maps before it marks its slot, so that after the request exactly one bit is set across the two maps.
- R7: An insert request (`hp_insert`=1) sets bit `hp_slot` of the arrival map. A remove request (`hp_insert`=0) sets bit `hp_slot` of the departure map.
- R8: Every hotplug request sets status bit 1 (register bit 1 at 0xC) and enable bit 1 (register bit 17 at 0xC) of the event register.
- R9: `sci` is high for exactly the one cycle after each request edge. The map and event updates are readable in that same cycle.
- R10: Writing 0xC clears each status bit written as 1 and leaves status bits written as 0 unchanged. The same write loads the enable bits directly from data bits [31:16].
- R11: When a request and a bus write land on the same edge, the request wins. Both maps take only the request's result, and event status bit 1 and enable bit 1 end set whatever the write carried. The write's other event bits still apply.
- R12: After reset both maps, all status and enable bits, `sci` and `ej_valid` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 5 | Register byte address |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| hp_valid | input | 1 | Hotplug request strobe |
| hp_insert | input | 1 | 1 = device inserted, 0 = device removed |
| hp_slot | input | 5 | Slot number of the request |
| sci | output | 1 | One-cycle system-control interrupt pulse |
| ej_valid | output | 1 | Eject slot index valid (one cycle) |
| ej_slot | output | 5 | Decoded eject slot index |

## Verification
A hotplug request and a firmware bus write can hit the same register on the same edge. The bench provokes this twice, with the request strobe and the write strobe driven in one cycle. In the first case the write targets the arrival map with a different pattern. In the second case it targets the event register with a pattern that clears status bit 1 and disables enable bit 1. The expected read-back in each case is the request's result alone, with the write's remaining event bits applied. The scoreboard judges both cases through the bus in the cycles after the edge, alongside the interrupt pulse it expects in that window.

// File: rtl/hpe_pkg.sv
package hpe_pkg;

    localparam int DATA_W   = 32;
    localparam int NSLOT    = DATA_W;
    localparam int SLOT_W   = $clog2(NSLOT);
    localparam int EVT_W    = 16;
    localparam int HP_BIT   = 1;
    localparam int ADDR_W   = 5;

    localparam int OFS_UP   = 'h0;
    localparam int OFS_DN   = 'h4;
    localparam int OFS_EJ   = 'h8;
    localparam int OFS_EVT  = 'hC;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_UP,
        SEL_DN,
        SEL_EJ,
        SEL_EVT
    } reg_sel_e;

    typedef struct packed {
        logic              valid;
        logic              insert;
        logic [SLOT_W-1:0] slot;
    } hp_req_t;

    function automatic reg_sel_e decode_addr(input logic [ADDR_W-1:0] a);
        reg_sel_e s;
        s = SEL_NONE;
        if (a[1:0] == 2'b00) begin
            case (int'(a))
                OFS_UP:  s = SEL_UP;
                OFS_DN:  s = SEL_DN;
                OFS_EJ:  s = SEL_EJ;
                OFS_EVT: s = SEL_EVT;
                default: s = SEL_NONE;
            endcase
        end
        return s;
    endfunction

endpackage

// File: rtl/hpe_slot_maps.sv
module hpe_slot_maps
    import hpe_pkg::*;
#(
    parameter int NS = NSLOT,
    localparam int SW = $clog2(NS)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          req_valid,
    input  logic          req_insert,
    input  logic [SW-1:0] req_slot,
    input  logic          wr_up,
    input  logic          wr_dn,
    input  logic [NS-1:0] wdata,
    output logic [NS-1:0] up_map,
    output logic [NS-1:0] dn_map
);

    logic [NS-1:0] slot_oh;

    always_comb begin
        slot_oh = '0;
        slot_oh[req_slot] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            up_map <= '0;
            dn_map <= '0;
        end else if (req_valid) begin
            up_map <= req_insert ? slot_oh : '0;
            dn_map <= req_insert ? '0 : slot_oh;
        end else begin
            if (wr_up) up_map <= wdata;
            if (wr_dn) dn_map <= wdata;
        end
    end

endmodule

// File: rtl/hpe_evt_regs.sv
module hpe_evt_regs
    import hpe_pkg::*;
#(
    parameter int EW  = EVT_W,
    parameter int BIT = HP_BIT
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          set_evt,
    input  logic          wr,
    input  logic [EW-1:0] w_sts,
    input  logic [EW-1:0] w_en,
    output logic [EW-1:0] sts,
    output logic [EW-1:0] en
);

    logic [EW-1:0] set_mask;
    logic [EW-1:0] clr_mask;

    always_comb begin
        set_mask = '0;
        set_mask[BIT] = set_evt;
        clr_mask = wr ? w_sts : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sts <= '0;
            en  <= '0;
        end else begin
            sts <= (sts & ~clr_mask) | set_mask;
            en  <= (wr ? w_en : en) | set_mask;
        end
    end

endmodule

// File: rtl/hpe_eject_dec.sv
module hpe_eject_dec
    import hpe_pkg::*;
#(
    parameter int DW = DATA_W,
    localparam int SW = $clog2(DW)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr,
    input  logic [DW-1:0] wdata,
    output logic          ej_valid,
    output logic [SW-1:0] ej_slot
);

    logic [SW-1:0] low_idx;

    always_comb begin
        low_idx = '0;
        for (int i = DW - 1; i >= 0; i--) begin
            if (wdata[i]) low_idx = SW'(i);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ej_valid <= 1'b0;
            ej_slot  <= '0;
        end else begin
            ej_valid <= wr && (wdata != '0);
            if (wr && (wdata != '0)) ej_slot <= low_idx;
        end
    end

endmodule

// File: rtl/hpe_regbank.sv
module hpe_regbank
    import hpe_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int DW = DATA_W,
    parameter int EW = EVT_W,
    localparam int SW = $clog2(DW)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] bus_addr,
    input  logic          bus_we,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    input  logic          hp_valid,
    input  logic          hp_insert,
    input  logic [SW-1:0] hp_slot,
    output logic          sci,
    output logic          ej_valid,
    output logic [SW-1:0] ej_slot
);

    reg_sel_e      sel;
    hp_req_t       req;
    logic [DW-1:0] up_map;
    logic [DW-1:0] dn_map;
    logic [EW-1:0] evt_sts;
    logic [EW-1:0] evt_en;

    always_comb begin
        sel        = decode_addr(ADDR_W'(bus_addr));
        req.valid  = hp_valid;
        req.insert = hp_insert;
        req.slot   = hp_slot;
    end

    hpe_slot_maps #(.NS(DW)) u_maps (
        .clk        (clk),
        .rst        (rst),
        .req_valid  (req.valid),
        .req_insert (req.insert),
        .req_slot   (req.slot),
        .wr_up      (bus_we && sel == SEL_UP),
        .wr_dn      (bus_we && sel == SEL_DN),
        .wdata      (bus_wdata),
        .up_map     (up_map),
        .dn_map     (dn_map)
    );

    hpe_evt_regs #(.EW(EW), .BIT(HP_BIT)) u_evt (
        .clk     (clk),
        .rst     (rst),
        .set_evt (req.valid),
        .wr      (bus_we && sel == SEL_EVT),
        .w_sts   (bus_wdata[EW-1:0]),
        .w_en    (bus_wdata[2*EW-1:EW]),
        .sts     (evt_sts),
        .en      (evt_en)
    );

    hpe_eject_dec #(.DW(DW)) u_ej (
        .clk      (clk),
        .rst      (rst),
        .wr       (bus_we && sel == SEL_EJ),
        .wdata    (bus_wdata),
        .ej_valid (ej_valid),
        .ej_slot  (ej_slot)
    );

    always_ff @(posedge clk) begin
        if (rst) sci <= 1'b0;
        else     sci <= req.valid;
    end

    always_comb begin
        case (sel)
            SEL_UP:  bus_rdata = up_map;
            SEL_DN:  bus_rdata = dn_map;
            SEL_EVT: bus_rdata = DW'({evt_en, evt_sts});
            default: bus_rdata = '0;
        endcase
    end

endmodule

// File: rtl/hpe_chk.sv
module hpe_chk
    import hpe_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int DW = DATA_W,
    parameter int EW = EVT_W,
    localparam int SW = $clog2(DW)
) (
    input logic          clk,
    input logic          rst,
    input logic [AW-1:0] bus_addr,
    input logic          bus_we,
    input logic [DW-1:0] bus_wdata,
    input logic [DW-1:0] bus_rdata,
    input logic          hp_valid,
    input logic          hp_insert,
    input logic [SW-1:0] hp_slot,
    input logic          sci,
    input logic          ej_valid,
    input logic [DW-1:0] up_map,
    input logic [DW-1:0] dn_map,
    input logic [EW-1:0] evt_sts,
    input logic [EW-1:0] evt_en
);

    logic ej_wr;
    assign ej_wr = bus_we && (int'(bus_addr) == OFS_EJ);

    AST_RESET_CLEAR: assert property (@(posedge clk)
        rst |=> (up_map == '0 && dn_map == '0 && evt_sts == '0 && evt_en == '0 && !sci && !ej_valid)); // R12

    AST_SCI_ON_REQ: assert property (@(posedge clk) disable iff (rst)
        hp_valid |=> sci); // R9

    AST_SCI_NO_REQ: assert property (@(posedge clk) disable iff (rst)
        !hp_valid |=> !sci); // R9

    AST_MAP_SINGLE: assert property (@(posedge clk) disable iff (rst)
        hp_valid |=> ($countones(up_map) + $countones(dn_map)) == 1); // R6

    AST_INSERT_SIDE: assert property (@(posedge clk) disable iff (rst)
        (hp_valid && hp_insert) |=> up_map == ({{(DW-1){1'b0}}, 1'b1} << $past(hp_slot))); // R7

    AST_REMOVE_SIDE: assert property (@(posedge clk) disable iff (rst)
        (hp_valid && !hp_insert) |=> dn_map == ({{(DW-1){1'b0}}, 1'b1} << $past(hp_slot))); // R7

    AST_EVT_SET: assert property (@(posedge clk) disable iff (rst)
        hp_valid |=> (evt_sts[HP_BIT] && evt_en[HP_BIT])); // R8

    AST_EJ_ZERO: assert property (@(posedge clk) disable iff (rst)
        (ej_wr && bus_wdata == '0) |=> !ej_valid); // R5

    AST_EJ_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
        !ej_wr |=> !ej_valid); // R4

    AST_EJ_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
        (int'(bus_addr) == OFS_EJ) |-> bus_rdata == '0); // R3

endmodule

bind hpe_regbank hpe_chk #(.AW(AW), .DW(DW), .EW(EW)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_addr  (bus_addr),
    .bus_we    (bus_we),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .hp_valid  (hp_valid),
    .hp_insert (hp_insert),
    .hp_slot   (hp_slot),
    .sci       (sci),
    .ej_valid  (ej_valid),
    .up_map    (up_map),
    .dn_map    (dn_map),
    .evt_sts   (evt_sts),
    .evt_en    (evt_en)
);

// File: tb/sim_hpe_regbank.sv
`timescale 1ns/1ps
module sim_hpe_regbank;

    localparam int K_RD  = 0;
    localparam int K_SCI = 1;
    localparam int K_EJ  = 2;

    typedef struct {
        int          cyc;
        int          kind;
        logic [31:0] exp;
        string       tag;
    } item_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [4:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        hp_valid = 1'b0;
    logic        hp_insert = 1'b0;
    logic [4:0]  hp_slot = '0;
    logic        sci;
    logic        ej_valid;
    logic [4:0]  ej_slot;

    int    cyc = 0;
    int    n_chk = 0;
    int    n_bad = 0;
    bit    done = 1'b0;
    item_t sb[$];

    hpe_regbank u0 (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .hp_valid(hp_valid),
        .hp_insert(hp_insert), .hp_slot(hp_slot), .sci(sci),
        .ej_valid(ej_valid), .ej_slot(ej_slot)
    );

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [4:0] low_bit(input logic [31:0] v);
        logic [4:0] r = '0;
        for (int i = 31; i >= 0; i--) if (v[i]) r = 5'(i);
        return r;
    endfunction

    task automatic push(input int c, input int k, input logic [31:0] e, input string t);
        item_t it;
        it.cyc = c; it.kind = k; it.exp = e; it.tag = t;
        sb.push_back(it);
    endtask

    // monitor: compare scoreboard items due in this cycle
    always @(negedge clk) begin
        while (sb.size() > 0 && sb[0].cyc <= cyc) begin
            item_t it;
            logic [31:0] act;
            it = sb.pop_front();
            case (it.kind)
                K_RD:    act = bus_rdata;
                K_SCI:   act = {31'b0, sci};
                default: act = ej_valid ? {26'b0, 1'b1, ej_slot} : 32'b0;
            endcase
            n_chk++;
            if (act !== it.exp || it.cyc != cyc) begin
                n_bad++;
                $display("FAIL %s: actual %h expected %h (cycle %0d)", it.tag, act, it.exp, cyc);
            end
        end
    end

    task automatic bus_write(input logic [4:0] a, input logic [31:0] d, input string t);
        int c0;
        @(posedge clk); #1;
        bus_addr = a; bus_we = 1'b1; bus_wdata = d;
        c0 = cyc;
        push(c0 + 1, K_EJ, (a == 5'h8 && d != 0) ? {26'b0, 1'b1, low_bit(d)} : 32'b0, t);
        push(c0 + 2, K_EJ, 32'b0, t);
        @(posedge clk); #1;
        bus_we = 1'b0;
    endtask

    task automatic bus_read(input logic [4:0] a, input logic [31:0] e, input string t);
        @(posedge clk); #1;
        bus_addr = a;
        push(cyc, K_RD, e, t);
    endtask

    task automatic hotplug(input logic [4:0] s, input logic ins, input bit with_wr,
                           input logic [4:0] a, input logic [31:0] d);
        int c0;
        @(posedge clk); #1;
        hp_valid = 1'b1; hp_insert = ins; hp_slot = s;
        if (with_wr) begin bus_addr = a; bus_we = 1'b1; bus_wdata = d; end
        c0 = cyc;
        push(c0 + 1, K_SCI, 32'd1, "R9 sci pulse high");
        push(c0 + 2, K_SCI, 32'd0, "R9 sci pulse one cycle");
        @(posedge clk); #1;
        hp_valid = 1'b0; bus_we = 1'b0;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        // R12 reset state
        push(cyc, K_SCI, 32'd0, "R12 sci after reset");
        push(cyc, K_EJ, 32'd0, "R12 ej after reset");
        bus_read(5'h0, 32'h0, "R12 up map reset");
        bus_read(5'h4, 32'h0, "R12 down map reset");
        bus_read(5'hC, 32'h0, "R12 event reset");
        // R1 read back
        bus_write(5'h0, 32'hA5A5_0001, "R1 write up");
        bus_write(5'h4, 32'h0000_1234, "R1 write down");
        bus_read(5'h0, 32'hA5A5_0001, "R1 up readback");
        bus_read(5'h4, 32'h0000_1234, "R1 down readback");
        // R2 unmapped offsets
        bus_write(5'h10, 32'hFFFF_FFFF, "R2 write 0x10");
        bus_write(5'h02, 32'hFFFF_FFFF, "R2 write 0x02");
        bus_write(5'h11, 32'hFFFF_FFFF, "R2 write 0x11");
        bus_read(5'h10, 32'h0, "R2 read 0x10");
        bus_read(5'h1C, 32'h0, "R2 read 0x1C");
        bus_read(5'h05, 32'h0, "R2 read 0x05");
        bus_read(5'h0, 32'hA5A5_0001, "R2 up unchanged");
        bus_read(5'h4, 32'h0000_1234, "R2 down unchanged");
        bus_read(5'hC, 32'h0, "R2 event unchanged");
        // R3 R4 R5 eject
        bus_write(5'h8, 32'h0000_0050, "R4 eject slot 4");
        bus_write(5'h8, 32'h8000_0000, "R4 eject slot 31");
        bus_write(5'h8, 32'hFFFF_FFFF, "R4 eject slot 0");
        bus_write(5'h8, 32'h0, "R5 eject zero");
        bus_read(5'h8, 32'h0, "R3 eject reads zero");
        // R6 R7 R8 R9 hotplug
        hotplug(5'd3, 1'b1, 1'b0, 5'h0, 32'h0);
        bus_read(5'h0, 32'h0000_0008, "R7 insert sets up bit");
        bus_read(5'h4, 32'h0, "R6 down cleared by insert");
        bus_read(5'hC, 32'h0002_0002, "R8 event bits set");
        hotplug(5'd31, 1'b0, 1'b0, 5'h0, 32'h0);
        bus_read(5'h0, 32'h0, "R6 up cleared by remove");
        bus_read(5'h4, 32'h8000_0000, "R7 remove sets down bit");
        // R10 W1C status, direct enable
        bus_write(5'hC, 32'h0005_0000, "R10 write enable only");
        bus_read(5'hC, 32'h0005_0002, "R10 status kept on zero write");
        bus_write(5'hC, 32'h0001_0002, "R10 clear status bit1");
        bus_read(5'hC, 32'h0001_0000, "R10 status cleared enable loaded");
        // R11 collision on maps
        bus_write(5'h0, 32'h0000_FFFF, "R11 preload up");
        bus_write(5'h4, 32'h0000_FFFF, "R11 preload down");
        hotplug(5'd0, 1'b1, 1'b1, 5'h0, 32'hF0F0_F0F0);
        bus_read(5'h0, 32'h0000_0001, "R11 request wins on up map");
        bus_read(5'h4, 32'h0, "R11 down cleared in collision");
        // R11 collision on event register
        hotplug(5'd7, 1'b0, 1'b1, 5'hC, 32'h0008_0002);
        bus_read(5'hC, 32'h000A_0002, "R11 request wins on event bits");
        bus_read(5'h4, 32'h0000_0080, "R11 remove slot 7");
        repeat (4) @(posedge clk);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule